// File: doc/BRIEF.md
# Step/Direction Microstep Translator

This block converts a step/direction command stream into drive for a unipolar stepper motor. It produces four coil switch outputs for the two phases and, for each phase, a 16-bit current-reference duty value. Each duty value is also emitted as a fixed-period PWM waveform that an external low-pass filter turns into the analog reference for a chopper stage. A rising edge on the step input moves an internal microstep position by one step of the selected resolution, forward or backward according to the direction input.

The coil switch outputs always use the two-phases-on full-step sequence. They change only when the position crosses into a new quarter of the electrical cycle. The microstep resolution affects only the reference amplitudes. These come from two quarter-sine tables: a 16-point grid serves the binary divisions and a 10-point grid serves the 1/5 and 1/10 divisions. When no step arrives for a programmable idle time, a standby output rises and both duty values are halved until the next step.

Top module: `microstep_translator`

## Requirements
- R1: After reset, phase_o is 4'b1010 (bit 3 A, bit 2 A-bar, bit 1 B, bit 0 B-bar), duty_a_o is 65535, duty_b_o is 0 and standby_o is low.
- R2: step_i passes through a two-flop synchronizer. Each low-to-high transition moves the position by exactly one microstep. A high level held for any length adds no further step. A pulse only two clocks wide is still taken.
- R3: With dir_i high, each quarter crossing advances phase_o through 1010, 0110, 0101, 1001 and wraps back to 1010. With dir_i low it walks the same list backwards. The microstep mode does not change this list.
- R4: Exactly one of A and A-bar is active at any time, and exactly one of B and B-bar.
- R5: mode_i codes 0 to 4 select full, 1/2, 1/4, 1/8 and 1/16 step on a 16-position quarter grid, and code 7 acts as full step. Call the quarter q and the position s of N. For even q, duty A is round(65535·sin((N−s)·π/2N)) and duty B is round(65535·sin(s·π/2N)). For odd q the two are swapped. Values are within ±3 LSB.
- R6: mode_i codes 5 (1/5 step) and 6 (1/10 step) use a 10-position quarter grid with the same amplitude rule. Stepping wraps across quarters in both directions.
- R7: A change of mode_i moves the position to a full-step boundary. The quarter advances by one when 2·s ≥ N of the old mode; otherwise it stays.
- R8: After IDLE_CYCLES clocks with no detected step, standby_o rises. Both duties then become the floor of half their full value.
- R9: A detected step edge drops standby_o on the next clock and restarts the idle count.
- R10: Each PWM output repeats every PWM_PERIOD clocks. It is high for floor(duty·PWM_PERIOD/65536) of those clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Step command, rising edge active |
| dir_i | input | 1 | Direction, high = forward |
| mode_i | input | 3 | Microstep resolution code |
| phase_o | output | 4 | Coil switches {A, A-bar, B, B-bar} |
| duty_a_o | output | 16 | Phase A reference duty |
| duty_b_o | output | 16 | Phase B reference duty |
| ref_a_pwm_o | output | 1 | Phase A reference PWM |
| ref_b_pwm_o | output | 1 | Phase B reference PWM |
| standby_o | output | 1 | Idle current reduction active |

## Verification
The bench targets quarter wrap in both directions in full, 1/5 and 1/10 modes. A wrong modulus there would show a phase pattern that skips or repeats, or an amplitude that jumps instead of crossing zero. A held-high step input is included because a level-sensitive detector would run away through many steps. Mode changes are tested on either side of the half-way point to catch realignment that truncates instead of rounding. The idle timer is checked just before and just after its limit, followed by a wake-up step, because an off-by-window or sticky standby would leave the duties halved or full at the wrong time.

// File: rtl/mst_pkg.sv
// Shared constants and quarter-sine tables for the microstep translator.
// Assumes 16-bit amplitudes and at most 16 positions per quarter.
package mst_pkg;
    localparam int AMP_W = 16;
    localparam int SUB_W = 5;

    localparam logic [2:0] MODE_FULL  = 3'd0;
    localparam logic [2:0] MODE_HALF  = 3'd1;
    localparam logic [2:0] MODE_QTR   = 3'd2;
    localparam logic [2:0] MODE_8TH   = 3'd3;
    localparam logic [2:0] MODE_16TH  = 3'd4;
    localparam logic [2:0] MODE_5TH   = 3'd5;
    localparam logic [2:0] MODE_10TH  = 3'd6;

    // True when the mode uses the ten-position grid.
    function automatic logic grid_is_ten(input logic [2:0] mode);
        return (mode == MODE_5TH) || (mode == MODE_10TH);
    endfunction

    // Positions per quarter for the mode's grid.
    function automatic logic [SUB_W-1:0] grid_len(input logic [2:0] mode);
        return grid_is_ten(mode) ? SUB_W'(10) : SUB_W'(16);
    endfunction

    // Grid positions moved per microstep.
    function automatic logic [SUB_W-1:0] grid_stride(input logic [2:0] mode);
        case (mode)
            MODE_HALF:  return SUB_W'(8);
            MODE_QTR:   return SUB_W'(4);
            MODE_8TH:   return SUB_W'(2);
            MODE_16TH:  return SUB_W'(1);
            MODE_5TH:   return SUB_W'(2);
            MODE_10TH:  return SUB_W'(1);
            default:    return SUB_W'(16);
        endcase
    endfunction

    // Quarter sine, 16 intervals.
    function automatic logic [AMP_W-1:0] sine16(input logic [SUB_W-1:0] k);
        case (k)
            5'd0:  return 16'd0;
            5'd1:  return 16'd6424;
            5'd2:  return 16'd12785;
            5'd3:  return 16'd19024;
            5'd4:  return 16'd25079;
            5'd5:  return 16'd30893;
            5'd6:  return 16'd36409;
            5'd7:  return 16'd41575;
            5'd8:  return 16'd46340;
            5'd9:  return 16'd50659;
            5'd10: return 16'd54490;
            5'd11: return 16'd57797;
            5'd12: return 16'd60547;
            5'd13: return 16'd62713;
            5'd14: return 16'd64276;
            5'd15: return 16'd65219;
            default: return 16'd65535;
        endcase
    endfunction

    // Quarter sine, 10 intervals.
    function automatic logic [AMP_W-1:0] sine10(input logic [SUB_W-1:0] k);
        case (k)
            5'd0:  return 16'd0;
            5'd1:  return 16'd10252;
            5'd2:  return 16'd20251;
            5'd3:  return 16'd29752;
            5'd4:  return 16'd38521;
            5'd5:  return 16'd46340;
            5'd6:  return 16'd53019;
            5'd7:  return 16'd58392;
            5'd8:  return 16'd62328;
            5'd9:  return 16'd64728;
            default: return 16'd65535;
        endcase
    endfunction
endpackage

// File: rtl/mst_edge_sync.sv
// Synchronizes step and direction into the clock domain and flags each
// rising edge of step as a one-cycle pulse. Assumes SYNC_STAGES >= 2.
module mst_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic dir_i,
    output logic step_edge_o,
    output logic dir_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] step_sr;
    logic [MSB:0] dir_sr;
    logic         step_prev;

    // Shift both inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_sr   <= '0;
            dir_sr    <= '0;
            step_prev <= 1'b0;
        end else begin
            step_sr   <= {step_sr[MSB-1:0], step_i};
            dir_sr    <= {dir_sr[MSB-1:0], dir_i};
            step_prev <= step_sr[MSB];
        end
    end

    // Rising edge of the synchronized step.
    assign step_edge_o = step_sr[MSB] & ~step_prev;
    assign dir_o       = dir_sr[MSB];

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        step_edge_o |=> !step_edge_o);
endmodule

// File: rtl/mst_index.sv
// Keeps the microstep position as a quarter number plus a grid position
// inside the quarter. Moves by one stride per step edge, and snaps to a
// full-step boundary when the mode changes (which takes priority).
module mst_index
    import mst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_edge_i,
    input  logic             dir_i,
    input  logic [2:0]       mode_i,
    output logic [1:0]       quad_o,
    output logic [SUB_W-1:0] sub_o,
    output logic [2:0]       mode_o
);
    logic [1:0]       quad_q, quad_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    logic [2:0]       mode_q;
    logic             mode_chg;
    logic [SUB_W-1:0] len, stride;
    logic [SUB_W:0]   fwd_sum;

    assign mode_chg = (mode_i != mode_q);
    assign len      = grid_len(mode_q);
    assign stride   = grid_stride(mode_q);
    assign fwd_sum  = {1'b0, sub_q} + {1'b0, stride};

    // Next position: realign on mode change, else move on a step edge.
    always_comb begin
        quad_d = quad_q;
        sub_d  = sub_q;
        if (mode_chg) begin
            sub_d = '0;
            if ({sub_q, 1'b0} >= {1'b0, len})
                quad_d = quad_q + 2'd1;
        end else if (step_edge_i) begin
            if (dir_i) begin
                if (fwd_sum >= {1'b0, len}) begin
                    sub_d  = SUB_W'(fwd_sum - {1'b0, len});
                    quad_d = quad_q + 2'd1;
                end else begin
                    sub_d = fwd_sum[SUB_W-1:0];
                end
            end else begin
                if (sub_q >= stride) begin
                    sub_d = sub_q - stride;
                end else begin
                    sub_d  = sub_q + len - stride;
                    quad_d = quad_q - 2'd1;
                end
            end
        end
    end

    // Position and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quad_q <= '0;
            sub_q  <= '0;
            mode_q <= MODE_FULL;
        end else begin
            quad_q <= quad_d;
            sub_q  <= sub_d;
            mode_q <= mode_i;
        end
    end

    assign quad_o = quad_q;
    assign sub_o  = sub_q;
    assign mode_o = mode_q;

    a_r5_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q < grid_len(mode_q));
    a_r7_realign_full: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (sub_q == '0));
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_edge_i && !mode_chg) |=> $stable(quad_q) && $stable(sub_q));
endmodule

// File: rtl/mst_amp.sv
// Looks up the two phase amplitudes from the quarter and position, and
// halves them in standby. The registered duty values are the outputs.
module mst_amp
    import mst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       quad_i,
    input  logic [SUB_W-1:0] sub_i,
    input  logic [2:0]       mode_i,
    input  logic             standby_i,
    output logic [AMP_W-1:0] duty_a_o,
    output logic [AMP_W-1:0] duty_b_o
);
    logic [SUB_W-1:0] k_rise, k_fall;
    logic [AMP_W-1:0] amp_rise, amp_fall, amp_a, amp_b;

    assign k_rise = sub_i;
    assign k_fall = grid_len(mode_i) - sub_i;

    // Table lookup and quarter-dependent channel swap.
    always_comb begin
        amp_rise = grid_is_ten(mode_i) ? sine10(k_rise) : sine16(k_rise);
        amp_fall = grid_is_ten(mode_i) ? sine10(k_fall) : sine16(k_fall);
        if (quad_i[0]) begin
            amp_a = amp_rise;
            amp_b = amp_fall;
        end else begin
            amp_a = amp_fall;
            amp_b = amp_rise;
        end
    end

    // Register the duties, applying the standby cut.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_a_o <= '1;
            duty_b_o <= '0;
        end else begin
            duty_a_o <= standby_i ? (amp_a >> 1) : amp_a;
            duty_b_o <= standby_i ? (amp_b >> 1) : amp_b;
        end
    end

    a_r8_halved: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (duty_a_o[AMP_W-1] == 1'b0) && (duty_b_o[AMP_W-1] == 1'b0));
endmodule

// File: rtl/mst_ref_pwm.sv
// Turns each channel's 16-bit duty into a PWM waveform of PERIOD clocks
// that shares one free-running counter. High time is duty*PERIOD/2^16.
module mst_ref_pwm
    import mst_pkg::*;
#(
    parameter int PERIOD = 510,
    parameter int CH     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CH-1:0][AMP_W-1:0]  duty_i,
    output logic [CH-1:0]             pwm_o
);
    localparam int CNT_W  = $clog2(PERIOD);
    localparam int PROD_W = AMP_W + CNT_W + 1;

    logic [CNT_W-1:0] cnt;

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CNT_W'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [PROD_W-1:0] prod;
        logic [CNT_W:0]    thr;

        assign prod = PROD_W'(duty_i[c]) * PROD_W'(PERIOD);
        assign thr  = prod[AMP_W +: CNT_W+1];

        // Compare the counter against the scaled threshold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pwm_o[c] <= 1'b0;
            else
                pwm_o[c] <= ({1'b0, cnt} < thr);
        end
    end

    a_r10_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(PERIOD));
endmodule

// File: rtl/mst_idle.sv
// Counts clocks since the last step edge and raises standby when the
// count reaches IDLE_CYCLES. A step edge clears it at once.
module mst_idle #(
    parameter int IDLE_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_edge_i,
    output logic standby_o
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Idle counter and standby flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            standby_o <= 1'b0;
        end else if (step_edge_i) begin
            cnt       <= '0;
            standby_o <= 1'b0;
        end else if (!standby_o) begin
            if (cnt == CNT_W'(IDLE_CYCLES - 1))
                standby_o <= 1'b1;
            else
                cnt <= cnt + 1'b1;
        end
    end

    a_r9_wake_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_edge_i |=> !standby_o);
    a_r8_standby_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_o && !step_edge_i) |=> standby_o);
endmodule

// File: rtl/microstep_translator.sv
// Top level: step/direction to two-phase-on coil switching plus two PWM
// current references. Assumes step, dir and mode come from a slower
// controller; mode is treated as quasi-static and not synchronized.
module microstep_translator
    import mst_pkg::*;
#(
    parameter int PWM_PERIOD  = 510,
    parameter int IDLE_CYCLES = 20_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic        dir_i,
    input  logic [2:0]  mode_i,
    output logic [3:0]  phase_o,
    output logic [15:0] duty_a_o,
    output logic [15:0] duty_b_o,
    output logic        ref_a_pwm_o,
    output logic        ref_b_pwm_o,
    output logic        standby_o
);
    logic             step_edge, dir_s;
    logic [1:0]       quad;
    logic [SUB_W-1:0] sub;
    logic [2:0]       mode_r;
    logic [1:0][AMP_W-1:0] duty_pair;
    logic [1:0]       pwm_pair;

    mst_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
        .step_edge_o(step_edge), .dir_o(dir_s)
    );

    mst_index index_i (
        .clk(clk), .rst_n(rst_n), .step_edge_i(step_edge), .dir_i(dir_s),
        .mode_i(mode_i), .quad_o(quad), .sub_o(sub), .mode_o(mode_r)
    );

    mst_idle #(.IDLE_CYCLES(IDLE_CYCLES)) idle_i (
        .clk(clk), .rst_n(rst_n), .step_edge_i(step_edge), .standby_o(standby_o)
    );

    mst_amp amp_i (
        .clk(clk), .rst_n(rst_n), .quad_i(quad), .sub_i(sub), .mode_i(mode_r),
        .standby_i(standby_o), .duty_a_o(duty_a_o), .duty_b_o(duty_b_o)
    );

    assign duty_pair = {duty_b_o, duty_a_o};

    mst_ref_pwm #(.PERIOD(PWM_PERIOD), .CH(2)) pwm_i (
        .clk(clk), .rst_n(rst_n), .duty_i(duty_pair), .pwm_o(pwm_pair)
    );

    assign ref_a_pwm_o = pwm_pair[0];
    assign ref_b_pwm_o = pwm_pair[1];

    // Two-phases-on switch pattern for the current quarter.
    always_comb begin
        case (quad)
            2'd0:    phase_o = 4'b1010;
            2'd1:    phase_o = 4'b0110;
            2'd2:    phase_o = 4'b0101;
            default: phase_o = 4'b1001;
        endcase
    end

    a_r4_pair_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o[3:2]) == 1);
    a_r4_pair_b_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o[1:0]) == 1);
    a_r3_one_switch_per_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> $countones(phase_o ^ $past(phase_o)) == 2);
endmodule

// File: tb/microstep_translator_tb_top.sv
`timescale 1ns/1ps
module microstep_translator_tb_top;
    localparam int PERIOD = 510;
    localparam int IDLE   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        dir_i = 1'b1;
    logic [2:0]  mode_i = 3'd0;
    logic [3:0]  phase_o;
    logic [15:0] duty_a_o, duty_b_o;
    logic        ref_a_pwm_o, ref_b_pwm_o, standby_o;

    always #2 clk = ~clk;

    microstep_translator #(.PWM_PERIOD(PERIOD), .IDLE_CYCLES(IDLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
        .mode_i(mode_i), .phase_o(phase_o), .duty_a_o(duty_a_o),
        .duty_b_o(duty_b_o), .ref_a_pwm_o(ref_a_pwm_o),
        .ref_b_pwm_o(ref_b_pwm_o), .standby_o(standby_o)
    );

    typedef struct {
        string      tag;
        logic [3:0] ph;
        int         da;
        int         db;
        bit         sb;
    } exp_t;

    exp_t exp_q[$];
    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference model state.
    int mq = 0, msub = 0, mmode = 0;
    bit msb = 1'b0;

    function automatic int m_len(input int mode);
        return (mode == 5 || mode == 6) ? 10 : 16;
    endfunction

    function automatic int m_stride(input int mode);
        case (mode)
            1: return 8;
            2: return 4;
            3: return 2;
            4: return 1;
            5: return 2;
            6: return 1;
            default: return 16;
        endcase
    endfunction

    function automatic int m_sine(input int k, input int n);
        real x;
        x = 65535.0 * $sin(k * 3.141592653589793 / (2.0 * n));
        return int'(x);
    endfunction

    function automatic logic [3:0] m_phase(input int q);
        case (q)
            0: return 4'b1010;
            1: return 4'b0110;
            2: return 4'b0101;
            default: return 4'b1001;
        endcase
    endfunction

    // Driver side: build the expected item from the model and queue it.
    task automatic push_expect(input string tag);
        exp_t e;
        int n, a, b;
        n = m_len(mmode);
        if (mq % 2 == 0) begin
            a = m_sine(n - msub, n);
            b = m_sine(msub, n);
        end else begin
            a = m_sine(msub, n);
            b = m_sine(n - msub, n);
        end
        if (msb) begin
            a = a / 2;
            b = b / 2;
        end
        e.tag = tag; e.ph = m_phase(mq); e.da = a; e.db = b; e.sb = msb;
        exp_q.push_back(e);
    endtask

    task automatic do_step(input bit dir, input int hi, input string tag);
        int n, s;
        @(negedge clk) dir_i = dir;
        repeat (2) @(negedge clk);
        step_i = 1'b1;
        repeat (hi) @(negedge clk);
        step_i = 1'b0;
        repeat (8) @(negedge clk);
        n = m_len(mmode);
        s = m_stride(mmode);
        msb = 1'b0;
        if (dir) begin
            msub = msub + s;
            if (msub >= n) begin msub = msub - n; mq = (mq + 1) % 4; end
        end else begin
            if (msub >= s) msub = msub - s;
            else begin msub = msub + n - s; mq = (mq + 3) % 4; end
        end
        push_expect(tag);
    endtask

    task automatic set_mode(input int m, input string tag);
        @(negedge clk) mode_i = 3'(m);
        repeat (6) @(negedge clk);
        if (m != mmode) begin
            if (2 * msub >= m_len(mmode)) mq = (mq + 1) % 4;
            msub = 0;
            mmode = m;
        end
        push_expect(tag);
    endtask

    function automatic int absd(input int x, input int y);
        return (x > y) ? x - y : y - x;
    endfunction

    // Monitor side: pop expected items and compare with the ports.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            tests++;
            if (phase_o !== e.ph || standby_o !== e.sb ||
                absd(int'(duty_a_o), e.da) > 3 || absd(int'(duty_b_o), e.db) > 3) begin
                fails++;
                $display("FAIL %s: phase=%b sb=%0b da=%0d db=%0d expected phase=%b sb=%0b da=%0d db=%0d",
                         e.tag, phase_o, standby_o, duty_a_o, duty_b_o,
                         e.ph, e.sb, e.da, e.db);
            end
        end
    end

    task automatic check_val(input string tag, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // R10: count high cycles over one full PWM period on each channel.
    task automatic pwm_window(input string tag);
        int ha, hb, da, db;
        @(negedge clk);
        da = int'(duty_a_o);
        db = int'(duty_b_o);
        ha = 0; hb = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            ha += int'(ref_a_pwm_o);
            hb += int'(ref_b_pwm_o);
        end
        check_val({tag, " chA"}, ha, (da * PERIOD) / 65536);
        check_val({tag, " chB"}, hb, (db * PERIOD) / 65536);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        push_expect("R1 reset state");

        // R3: full-step sequence forward with wrap, then reverse.
        for (int i = 0; i < 4; i++) do_step(1'b1, 4, "R3 full forward");
        for (int i = 0; i < 3; i++) do_step(1'b0, 4, "R3 full reverse");

        // R2: a long high level gives one step; a two-clock pulse still counts.
        do_step(1'b1, 30, "R2 held high single step");
        do_step(1'b1, 2, "R2 short pulse");

        // R5: 1/16 microsteps through a quarter.
        set_mode(4, "R7 change to 1/16 at boundary");
        for (int i = 0; i < 5; i++) do_step(1'b1, 4, "R5 sixteenth forward");
        set_mode(3, "R7 realign below half");
        for (int i = 0; i < 3; i++) do_step(1'b1, 4, "R5 eighth forward");
        set_mode(4, "R7 back to 1/16");
        for (int i = 0; i < 11; i++) do_step(1'b1, 4, "R5 sixteenth run");
        set_mode(6, "R7 realign above half rounds up");

        // R6: 1/10 and 1/5 across quarter boundaries both ways.
        for (int i = 0; i < 3; i++) do_step(1'b0, 4, "R6 tenth reverse wrap");
        for (int i = 0; i < 5; i++) do_step(1'b1, 4, "R6 tenth forward");
        set_mode(5, "R7 realign to 1/5");
        for (int i = 0; i < 6; i++) do_step(1'b1, 4, "R6 fifth forward wrap");
        for (int i = 0; i < 2; i++) do_step(1'b0, 4, "R6 fifth reverse");

        // R5: half step and the reserved code acting as full step.
        set_mode(1, "R7 change to half");
        for (int i = 0; i < 3; i++) do_step(1'b1, 4, "R5 half forward");
        set_mode(7, "R5 code 7 as full");
        do_step(1'b1, 4, "R5 code 7 steps a full step");

        // R10: PWM high time matches the duty on both channels.
        set_mode(4, "R7 to 1/16 for PWM");
        for (int i = 0; i < 4; i++) do_step(1'b1, 4, "R5 sixteenth for PWM");
        pwm_window("R10 pwm mid duty");

        // R8 / R9: idle timer, halved duties and wake-up.
        do_step(1'b1, 4, "R9 step before idle");
        repeat (2880) @(negedge clk);
        check_val("R8 standby not yet", int'(standby_o), 0);
        repeat (300) @(negedge clk);
        msb = 1'b1;
        push_expect("R8 standby halves duties");
        repeat (2) @(negedge clk);
        do_step(1'b1, 4, "R9 step clears standby");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule